// File: doc/BRIEF.md
# Double-Buffered Four-Channel DAC Register Bank

This block sits between a host register bus and four 12-bit digital-to-analog converter channels, called A, B, C and D. The host writes a code for each channel and one shared range word into staging registers. The staged values reach the converters only when the host reads one of two update offsets. A read of the mode offset commits all four codes in one clock. A read of the range offset commits the range word. Because of this, every channel changes at the same instant and never shows a half-written set.

A small mode register holds two bits: an output enable and a buffered-mode select. With buffered mode off, each write goes straight to the live outputs and the update reads do nothing. With the enable off, the converter-facing outputs are held at code 0, unipolar and gain 0. The staged and live registers keep their contents while the enable is off.

Top module: `dacbank_top`

## Requirements
- R1: A write to byte offset 0x14, 0x16, 0x18 or 0x1A stages the low 12 bits of the write data for channel A, B, C or D respectively. Channel i (A=0) appears on `codeOut[12*i +: 12]`.
- R2: A write to offset 0x02 sets the output enable from data bit 1 and buffered mode from data bit 0. All other bits of that write are ignored.
- R3: In buffered mode, a read of offset 0x02 copies all four staged codes to the live outputs together. They are visible right after the clock edge on which the read strobe is sampled.
- R4: In buffered mode, data and range writes leave the live outputs unchanged until the matching update read.
- R5: A write to offset 0x12 stages the range word, and in buffered mode a read of 0x12 makes it live. Bipolar select for A, B, C, D is word bit 7, 6, 5, 4. Gain select is bit 11, 10, 9, 8. These appear on `bipolarOut[i]` and `gainOut[i]` with A=0. A data update does not move the range, and a range update does not move the data.
- R6: With buffered mode off, data and range writes reach the live outputs on the write's clock edge. Update reads have no effect.
- R7: While the enable is 0, all codes read 0 and all bipolar and gain selects read 0. Staged data is kept and can still be committed. The committed values show once the enable returns to 1.
- R8: After reset, the mode register, the range registers and all data registers are 0.
- R9: Writes and reads at offsets other than those above change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hostWrEn | input | 1 | Host write strobe, one cycle per access |
| hostRdEn | input | 1 | Host read strobe, one cycle per access |
| hostAddr | input | 5 | Host byte offset |
| hostWrData | input | 16 | Host write data |
| codeOut | output | 48 | Live 12-bit codes, channel A in the low bits |
| bipolarOut | output | 4 | Live bipolar select per channel, bit 0 = A |
| gainOut | output | 4 | Live gain select per channel, bit 0 = A |

## Verification
The range word is swept through all 256 settings of its eight meaningful bits. This separates the per-channel bit placement of bipolar and gain and catches any swap between channels or between the two fields. Sixty-four arithmetic code patterns per channel are staged and committed. The bench checks the outputs both before and after each update read, which separates early visibility from a missing commit. Mode changes are applied on top of partly staged data: a direct write, an update read with buffering off, a commit while disabled, and writes and reads to unused offsets. These show whether the enable gating, the direct path and the address decode reach the outputs or leave them alone.

// File: rtl/dacbank_pkg.sv
package dacbank_pkg;
  localparam int NUM_CH = 4;
  localparam int ADDR_W = 5;
  localparam logic [ADDR_W-1:0] OFS_MODE  = 5'h02;
  localparam logic [ADDR_W-1:0] OFS_RANGE = 5'h12;
  localparam logic [ADDR_W-1:0] OFS_DATA0 = 5'h14;
  localparam int ADDR_STEP = 2;
  localparam int BIP_MSB = 7;
  localparam int GAIN_MSB = 11;
  localparam int MODE_EN_BIT = 1;
  localparam int MODE_BUF_BIT = 0;

  typedef struct packed {
    logic [NUM_CH-1:0] dataWr;
    logic              rangeWr;
    logic              dataCommit;
    logic              rangeCommit;
    logic              passThru;
    logic              outEnable;
  } strobe_t;
endpackage

// File: rtl/dacbank_ctrl.sv
module dacbank_ctrl
  import dacbank_pkg::*;
#(
  parameter int BUS_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWrEn,
  input  logic              hostRdEn,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [BUS_W-1:0]  hostWrData,
  output strobe_t           stb
);
  logic modeEn;
  logic modeBuf;
  logic hitMode;
  logic hitRange;

  assign hitMode  = (hostAddr == OFS_MODE);
  assign hitRange = (hostAddr == OFS_RANGE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeEn  <= 1'b0;
      modeBuf <= 1'b0;
    end else if (hostWrEn && hitMode) begin
      modeEn  <= hostWrData[MODE_EN_BIT];
      modeBuf <= hostWrData[MODE_BUF_BIT];
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
    localparam logic [ADDR_W-1:0] CH_ADDR = ADDR_W'(int'(OFS_DATA0) + ADDR_STEP * i);
    assign stb.dataWr[i] = hostWrEn && (hostAddr == CH_ADDR);
  end

  assign stb.rangeWr     = hostWrEn && hitRange;
  assign stb.dataCommit  = hostRdEn && hitMode && modeBuf;
  assign stb.rangeCommit = hostRdEn && hitRange && modeBuf;
  assign stb.passThru    = !modeBuf;
  assign stb.outEnable   = modeEn;

  AST_MODE_TRACK: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrEn && hitMode) |=> (stb.outEnable == $past(hostWrData[MODE_EN_BIT]))
                              && (stb.passThru == !$past(hostWrData[MODE_BUF_BIT]))); // R2

  AST_NO_COMMIT_ON_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrEn && !hostRdEn) |-> !stb.dataCommit && !stb.rangeCommit); // R4
endmodule

// File: rtl/dacbank_path.sv
module dacbank_path
  import dacbank_pkg::*;
#(
  parameter int CODE_W = 12,
  parameter int BUS_W  = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  strobe_t                  stb,
  input  logic [BUS_W-1:0]         hostWrData,
  output logic [NUM_CH*CODE_W-1:0] codeOut,
  output logic [NUM_CH-1:0]        bipolarOut,
  output logic [NUM_CH-1:0]        gainOut
);
  logic [NUM_CH-1:0][CODE_W-1:0] dataStage;
  logic [NUM_CH-1:0][CODE_W-1:0] dataLive;
  logic [NUM_CH-1:0] bipStage, gainStage, bipLive, gainLive;
  logic [NUM_CH-1:0] bipIn, gainIn;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign bipIn[i]  = hostWrData[BIP_MSB - i];
    assign gainIn[i] = hostWrData[GAIN_MSB - i];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        dataStage[i] <= '0;
        dataLive[i]  <= '0;
      end else begin
        if (stb.dataWr[i]) dataStage[i] <= hostWrData[CODE_W-1:0];
        if (stb.passThru && stb.dataWr[i]) dataLive[i] <= hostWrData[CODE_W-1:0];
        else if (stb.dataCommit)          dataLive[i] <= dataStage[i];
      end
    end

    assign codeOut[i*CODE_W +: CODE_W] = stb.outEnable ? dataLive[i] : '0;

    AST_DIRECT_WRITE: assert property (@(posedge clk) disable iff (!rstN)
      (stb.passThru && stb.dataWr[i]) |=> dataLive[i] == $past(hostWrData[CODE_W-1:0])); // R6
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bipStage  <= '0;
      gainStage <= '0;
      bipLive   <= '0;
      gainLive  <= '0;
    end else begin
      if (stb.rangeWr) begin
        bipStage  <= bipIn;
        gainStage <= gainIn;
      end
      if (stb.passThru && stb.rangeWr) begin
        bipLive  <= bipIn;
        gainLive <= gainIn;
      end else if (stb.rangeCommit) begin
        bipLive  <= bipStage;
        gainLive <= gainStage;
      end
    end
  end

  assign bipolarOut = stb.outEnable ? bipLive  : '0;
  assign gainOut    = stb.outEnable ? gainLive : '0;

  AST_DATA_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    (stb.dataCommit && !(|stb.dataWr)) |=> dataLive == $past(dataStage)); // R3

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.dataCommit && !(stb.passThru && |stb.dataWr)) |=> $stable(dataLive)); // R4

  AST_RANGE_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rangeCommit && !stb.rangeWr) |=> (bipLive == $past(bipStage)) && (gainLive == $past(gainStage))); // R5

  AST_DISABLED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !stb.outEnable |-> (codeOut == '0) && (bipolarOut == '0) && (gainOut == '0)); // R7
endmodule

// File: rtl/dacbank_top.sv
module dacbank_top
  import dacbank_pkg::*;
#(
  parameter int CODE_W = 12,
  parameter int BUS_W  = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     hostWrEn,
  input  logic                     hostRdEn,
  input  logic [ADDR_W-1:0]        hostAddr,
  input  logic [BUS_W-1:0]         hostWrData,
  output logic [NUM_CH*CODE_W-1:0] codeOut,
  output logic [NUM_CH-1:0]        bipolarOut,
  output logic [NUM_CH-1:0]        gainOut
);
  strobe_t stb;

  dacbank_ctrl #(.BUS_W(BUS_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostRdEn(hostRdEn),
    .hostAddr(hostAddr), .hostWrData(hostWrData), .stb(stb)
  );

  dacbank_path #(.CODE_W(CODE_W), .BUS_W(BUS_W)) u_path (
    .clk(clk), .rstN(rstN), .stb(stb), .hostWrData(hostWrData),
    .codeOut(codeOut), .bipolarOut(bipolarOut), .gainOut(gainOut)
  );
endmodule

// File: tb/sim_dacbank_top.sv
`timescale 1ns/1ps
module sim_dacbank_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostWrEn = 1'b0;
  logic hostRdEn = 1'b0;
  logic [4:0] hostAddr = '0;
  logic [15:0] hostWrData = '0;
  logic [47:0] codeOut;
  logic [3:0] bipolarOut, gainOut;

  int nRun = 0;
  int nFail = 0;
  bit done = 1'b0;

  logic [11:0] mStage [4];
  logic [11:0] mLive [4];
  logic [3:0] mBipS, mGainS, mBipL, mGainL;
  logic mEn, mBuf;

  always #2 clk = ~clk;

  dacbank_top u0 (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostRdEn(hostRdEn),
    .hostAddr(hostAddr), .hostWrData(hostWrData),
    .codeOut(codeOut), .bipolarOut(bipolarOut), .gainOut(gainOut)
  );

  task automatic doWr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    hostWrEn = 1'b1; hostAddr = a; hostWrData = d;
    @(negedge clk);
    hostWrEn = 1'b0;
    if (a == 5'h02) begin
      mEn = d[1]; mBuf = d[0];
    end else if (a == 5'h12) begin
      for (int i = 0; i < 4; i++) begin
        mBipS[i] = d[7-i]; mGainS[i] = d[11-i];
      end
      if (!mBuf) begin mBipL = mBipS; mGainL = mGainS; end
    end else if (a == 5'h14 || a == 5'h16 || a == 5'h18 || a == 5'h1A) begin
      int idx;
      idx = (int'(a) - 20) / 2;
      mStage[idx] = d[11:0];
      if (!mBuf) mLive[idx] = d[11:0];
    end
  endtask

  task automatic doRd(input logic [4:0] a);
    @(negedge clk);
    hostRdEn = 1'b1; hostAddr = a;
    @(negedge clk);
    hostRdEn = 1'b0;
    if (mBuf && a == 5'h02) for (int i = 0; i < 4; i++) mLive[i] = mStage[i];
    if (mBuf && a == 5'h12) begin mBipL = mBipS; mGainL = mGainS; end
  endtask

  task automatic checkAll(input string tag);
    logic [47:0] eCode;
    logic [3:0] eBip, eGain;
    for (int i = 0; i < 4; i++) eCode[12*i +: 12] = mEn ? mLive[i] : 12'h000;
    eBip  = mEn ? mBipL  : 4'h0;
    eGain = mEn ? mGainL : 4'h0;
    nRun++;
    if (codeOut !== eCode || bipolarOut !== eBip || gainOut !== eGain) begin
      nFail++;
      $display("FAIL %s: code=%h bip=%b gain=%b expected code=%h bip=%b gain=%b",
               tag, codeOut, bipolarOut, gainOut, eCode, eBip, eGain);
    end
  endtask

  initial begin
    #600000;
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin mStage[i] = '0; mLive[i] = '0; end
    mBipS = '0; mGainS = '0; mBipL = '0; mGainL = '0; mEn = 0; mBuf = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R8 reset state");

    // R2: unrelated mode bits ignored, enable and buffered both off
    doWr(5'h02, 16'hFFFC);
    checkAll("R2 mode bits ignored");
    doWr(5'h02, 16'hFFF3);
    checkAll("R2 enable and buffered set");

    // R1 R4 R3: staged writes hidden until commit
    doWr(5'h14, 16'hF123); doWr(5'h16, 16'hA456);
    doWr(5'h18, 16'h5789); doWr(5'h1A, 16'h0ABC);
    checkAll("R4 data held before commit");
    doRd(5'h02);
    checkAll("R3 R1 four channels committed");

    // R5: full range sweep, each staged then committed
    for (int v = 0; v < 256; v++) begin
      doWr(5'h12, 16'(v << 4));
      checkAll("R4 range held before commit");
      doRd(5'h12);
      checkAll("R5 range committed");
    end

    // R3: code sweep, range untouched by data commits
    for (int k = 0; k < 64; k++) begin
      for (int c = 0; c < 4; c++)
        doWr(5'(20 + 2*c), 16'((k * 67 + c * 1031 + (k << 9)) & 16'hFFFF));
      checkAll("R4 codes held before commit");
      doRd(5'h02);
      checkAll("R3 R5 codes committed range kept");
    end

    // R9: unused offsets
    doWr(5'h00, 16'hFFFF); doWr(5'h04, 16'h1234); doWr(5'h1C, 16'h0FFF);
    doWr(5'h10, 16'h0777); doRd(5'h04); doRd(5'h14);
    checkAll("R9 unused offsets no effect");
    doRd(5'h02);
    checkAll("R9 staging untouched by unused offsets");

    // R6: stage in buffered mode, then switch off buffering; update read must not commit
    doWr(5'h16, 16'h0111);
    doWr(5'h02, 16'h0002);
    doRd(5'h02);
    checkAll("R6 update read ignored in direct mode");
    doWr(5'h14, 16'h0555);
    checkAll("R6 direct data write");
    doWr(5'h12, 16'h0A50);
    checkAll("R6 direct range write");
    doRd(5'h12);
    checkAll("R6 range read ignored");

    // R7: disable, commit while disabled, re-enable
    doWr(5'h02, 16'h0001);
    checkAll("R7 outputs zero when disabled");
    doWr(5'h1A, 16'h0ABD); doWr(5'h12, 16'h0F0F);
    doRd(5'h02); doRd(5'h12);
    checkAll("R7 still zero after commit while disabled");
    doWr(5'h02, 16'h0003);
    checkAll("R7 staged values shown after enable");

    // R8: reset in the middle clears everything
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    for (int i = 0; i < 4; i++) begin mStage[i] = '0; mLive[i] = '0; end
    mBipS = '0; mGainS = '0; mBipL = '0; mGainL = '0; mEn = 0; mBuf = 0;
    doWr(5'h02, 16'h0003);
    doRd(5'h02); doRd(5'h12);
    checkAll("R8 registers cleared by reset");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule